// File: doc/BRIEF.md
# Serial Control-Port Register File

This block is a serial slave that lets an external master read and write a bank of 8-bit registers inside a chip. The master frames each transaction with an active-low select. The first byte carries a 7-bit device identifier and a direction bit. A write frame continues with a control byte: an auto-increment flag and a 7-bit register pointer, then any number of data bytes. The register contents are presented to the core on a flat parallel bus. A configurable subset of entries is read-only and reflects status inputs driven by the core.

Reading takes two frames. A first write frame carries only the control byte and is closed by raising select. This leaves the pointer and the auto-increment flag in place. A second frame sends the identifier with the direction bit set, and the slave then shifts register bytes out for as long as select stays low. With auto-increment, the pointer steps after every byte and wraps from the last entry back to zero. Without it, the same entry is returned again and again, so a status register can be polled. All serial inputs are brought into the system clock domain through two-flop synchronisers. The serial clock must therefore run at no more than a quarter of the system clock.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every writable register reads 0x00, `reg_q` is all zero and the data output is released (`miso_oe`=0, `miso` high-impedance).
- R2: Every field is sent MSB first. The first byte is the 7-bit identifier 0100000 followed by the direction bit (0 = write, 1 = read). In a write frame the second byte is the auto-increment flag in bit 7 and the pointer in bits 6:0; its low five bits select the register. Input bits are taken on the rising serial-clock edge, and output bits change on the falling edge.
- R3: In a write frame, each complete data byte after the control byte is stored at the pointer. Register n appears on `reg_q[8n+7:8n]`.
- R4: With auto-increment set, the pointer advances after every data byte in both write and read frames, and it wraps from 31 to 0.
- R5: With auto-increment clear, the pointer holds. Successive write bytes land in the same register, and successive read bytes return the same register.
- R6: A frame with the direction bit set shifts out the register at the pointer left by the preceding write frame, starting with the falling edge that follows the identifier byte.
- R7: `miso_oe` is high only while read data is being shifted; `miso` is high-impedance whenever `miso_oe` is low.
- R8: Registers flagged in `RO_MASK` (default 4 to 7) ignore writes and keep 0x00 on `reg_q`. Reads of them return the value of `stat_in` at the moment the byte is loaded.
- R9: A frame whose identifier differs from 0100000 changes nothing and never enables the output.
- R10: Raising select ends the frame at once: a partly received byte is dropped and the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out, high-impedance when released |
| miso_oe | output | 1 | High while `miso` is driven |
| reg_q | output | NREG*8 | All registers, register n at bits 8n+7:8n |
| stat_in | input | NREG*8 | Core status, read back for read-only entries |

## Verification
Bursts with auto-increment are run from a middle pointer and from pointers just below the top of the bank. These show a correct step-and-wrap apart from a stuck or overflowing pointer. Multi-byte writes and reads with the flag clear separate polling from accidental advancing. Frames with a wrong identifier, writes aimed at read-only entries, and a frame cut short mid-byte must all leave the bus unchanged. Read frames also check the output enable bit by bit, so a slave that drives the line during the header or after select rises is caught.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int              NREG    = 32,
  parameter logic [6:0]      DEV_ID  = 7'b0100000,
  parameter logic [NREG-1:0] RO_MASK = 32'h0000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [NREG*8-1:0] reg_q,
  input  logic [NREG*8-1:0] stat_in
);
  localparam int PW = $clog2(NREG);
  localparam logic [2:0] P_DEV = 3'd0, P_PTR = 3'd1, P_WR = 3'd2,
                         P_RD = 3'd3, P_SKIP = 3'd4;

  logic [2:0]    sclk_p;
  logic [1:0]    mosi_p, cs_p;
  logic          rise, fall, cs_s, mosi_s;
  logic [2:0]    phase;
  logic [2:0]    bcnt, rcnt;
  logic [6:0]    sh;
  logic [7:0]    byte_in, tx, rd_val;
  logic [PW-1:0] ptr, nxt;
  logic          ai, dout, oe, wr_hit;
  logic [7:0]    regs [NREG];

  assign rise    = sclk_p[1] & ~sclk_p[2];
  assign fall    = ~sclk_p[1] & sclk_p[2];
  assign cs_s    = cs_p[1];
  assign mosi_s  = mosi_p[1];
  assign byte_in = {sh, mosi_s};
  assign nxt     = (ptr == PW'(NREG-1)) ? '0 : ptr + 1'b1;
  assign rd_val  = RO_MASK[ptr] ? stat_in[ptr*8 +: 8] : regs[ptr];
  assign wr_hit  = !cs_s && rise && bcnt == 3'd7 && phase == P_WR && !RO_MASK[ptr];
  assign miso    = oe ? dout : 1'bz;
  assign miso_oe = oe;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_q[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      mosi_p <= '0;
      cs_p   <= 2'b11;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      mosi_p <= {mosi_p[0], mosi};
      cs_p   <= {cs_p[0], cs_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_DEV;
      bcnt  <= '0;
      rcnt  <= '0;
      sh    <= '0;
      tx    <= '0;
      ptr   <= '0;
      ai    <= 1'b0;
      dout  <= 1'b0;
      oe    <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (cs_s) begin
      phase <= P_DEV;
      bcnt  <= '0;
      rcnt  <= '0;
      oe    <= 1'b0;
    end else begin
      if (rise) begin
        sh   <= byte_in[6:0];
        bcnt <= bcnt + 1'b1;
        if (bcnt == 3'd7) begin
          case (phase)
            P_DEV: begin
              if (byte_in[7:1] != DEV_ID) phase <= P_SKIP;
              else if (byte_in[0])        phase <= P_RD;
              else                        phase <= P_PTR;
            end
            P_PTR: begin
              ai    <= byte_in[7];
              ptr   <= byte_in[PW-1:0];
              phase <= P_WR;
            end
            P_WR: begin
              if (!RO_MASK[ptr]) regs[ptr] <= byte_in;
              if (ai) ptr <= nxt;
            end
            P_RD: if (ai) ptr <= nxt;
            default: ;
          endcase
        end
      end
      if (fall && phase == P_RD) begin
        oe   <= 1'b1;
        rcnt <= rcnt + 1'b1;
        if (rcnt == 3'd0) begin
          dout <= rd_val[7];
          tx   <= {rd_val[6:0], 1'b0};
        end else begin
          dout <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

module spi_regfile_slave_chk #(
  parameter int NREG = 32,
  parameter int PW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              rise,
  input logic              fall,
  input logic              oe,
  input logic              dout,
  input logic              ai,
  input logic              wr_hit,
  input logic [2:0]        phase,
  input logic [2:0]        bcnt,
  input logic [PW-1:0]     ptr,
  input logic [NREG*8-1:0] reg_q
);
  localparam logic [2:0] C_WR = 3'd2, C_RD = 3'd3;

  a_r7_oe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> phase == C_RD);
  a_r10_select_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!oe && bcnt == 3'd0));
  a_r4_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && rise && bcnt == 3'd7 && phase == C_RD && ai && ptr == PW'(NREG-1)) |=> ptr == '0);
  a_r5_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && rise && bcnt == 3'd7 && (phase == C_RD || phase == C_WR) && !ai) |=> $stable(ptr));
  a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(reg_q));
  a_r2_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dout));
endmodule

bind spi_regfile_slave spi_regfile_slave_chk #(.NREG(NREG), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise), .fall(fall), .oe(oe),
  .dout(dout), .ai(ai), .wr_hit(wr_hit), .phase(phase), .bcnt(bcnt),
  .ptr(ptr), .reg_q(reg_q)
);

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam time HALF = 40ns;
  localparam logic [6:0] ID = 7'b0100000;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0;
  logic miso, miso_oe;
  logic [255:0] reg_q, stat_in;
  logic [7:0] model [32];
  int n_chk = 0, n_bad = 0, oe_seen;

  spi_regfile_slave u_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_q(reg_q), .stat_in(stat_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] model_vec();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic xfer(input logic [7:0] d, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = d[i];
      #HALF;
      sclk = 1;
      r[i] = miso;
      if (miso_oe) oe_seen++;
      #HALF;
      sclk = 0;
    end
  endtask

  task automatic start(); cs_n = 0; #HALF; endtask
  task automatic stop();  #HALF; cs_n = 1; #(4*HALF); endtask

  task automatic wr_frame(input logic [6:0] id, input logic inc, input logic [6:0] p,
                          input logic [7:0] d [], input int last_bits);
    logic [7:0] r;
    start();
    xfer({id, 1'b0}, 8, r);
    xfer({inc, p}, 8, r);
    foreach (d[k]) xfer(d[k], (k == d.size() - 1) ? last_bits : 8, r);
    stop();
  endtask

  task automatic rd_frame(input logic [6:0] id, input int n, output logic [7:0] q [],
                          output int hdr_oe, output int dat_oe);
    logic [7:0] r;
    q = new[n];
    start();
    oe_seen = 0;
    xfer({id, 1'b1}, 8, r);
    hdr_oe = oe_seen;
    oe_seen = 0;
    for (int k = 0; k < n; k++) begin xfer(8'h00, 8, r); q[k] = r; end
    dat_oe = oe_seen;
    stop();
  endtask

  task automatic set_ptr(input logic inc, input logic [6:0] p);
    logic [7:0] none [];
    none = new[0];
    wr_frame(ID, inc, p, none, 8);
  endtask

  task automatic t_reset();
    chk("R1 reg_q", reg_q, '0);
    chk("R1 oe", miso_oe, 0);
    chk("R7 idle hi-z", miso, 1'bz);
  endtask

  task automatic t_no_inc_write();
    logic [7:0] q []; int h, d;
    wr_frame(ID, 1'b0, 7'd2, '{8'h11, 8'h22, 8'h33}, 8);
    model[2] = 8'h33;
    chk("R5 R3 same reg", reg_q, model_vec());
    set_ptr(1'b0, 7'd2);
    rd_frame(ID, 3, q, h, d);
    for (int k = 0; k < 3; k++) chk("R5 poll", q[k], 8'h33);
  endtask

  task automatic t_burst();
    logic [7:0] q []; int h, d;
    logic [7:0] v [];
    v = new[8];
    for (int k = 0; k < 8; k++) begin v[k] = 8'h3C ^ 8'(k * 29); model[8 + k] = v[k]; end
    wr_frame(ID, 1'b1, 7'd8, v, 8);
    chk("R3 R4 burst write", reg_q, model_vec());
    set_ptr(1'b1, 7'd8);
    rd_frame(ID, 8, q, h, d);
    for (int k = 0; k < 8; k++) chk("R6 R2 burst read", q[k], model[8 + k]);
    chk("R7 header not driven", h, 0);
    chk("R7 data driven", d, 64);
  endtask

  task automatic t_wrap();
    logic [7:0] q []; int h, d;
    wr_frame(ID, 1'b1, 7'd30, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, 8);
    model[30] = 8'hA1; model[31] = 8'hB2; model[0] = 8'hC3; model[1] = 8'hD4;
    chk("R4 write wrap", reg_q, model_vec());
    set_ptr(1'b1, 7'd31);
    rd_frame(ID, 3, q, h, d);
    chk("R4 read wrap 31", q[0], 8'hB2);
    chk("R4 read wrap 0", q[1], 8'hC3);
    chk("R4 read wrap 1", q[2], 8'hD4);
    chk("R7 released after frame", miso_oe, 0);
  endtask

  task automatic t_read_only();
    logic [7:0] q []; int h, d;
    wr_frame(ID, 1'b1, 7'd4, '{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 8);
    chk("R8 writes ignored", reg_q, model_vec());
    set_ptr(1'b1, 7'd3);
    model[3] = 8'h00;
    rd_frame(ID, 5, q, h, d);
    for (int k = 0; k < 4; k++) chk("R8 status read", q[k + 1], stat_in[(4 + k)*8 +: 8]);
    stat_in[5*8 +: 8] = 8'h6E;
    set_ptr(1'b0, 7'd5);
    rd_frame(ID, 2, q, h, d);
    chk("R8 live status", q[1], 8'h6E);
  endtask

  task automatic t_bad_id();
    logic [7:0] q []; int h, d;
    wr_frame(7'b0100001, 1'b0, 7'd2, '{8'h77}, 8);
    chk("R9 foreign write ignored", reg_q, model_vec());
    rd_frame(7'b1100000, 2, q, h, d);
    chk("R9 output stays off", h + d, 0);
  endtask

  task automatic t_cut_short();
    wr_frame(ID, 1'b0, 7'd9, '{8'h5A}, 5);
    chk("R10 partial byte dropped", reg_q, model_vec());
    chk("R10 output released", miso_oe, 0);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      model[i] = '0;
      stat_in[i*8 +: 8] = 8'(i * 17) ^ 8'hA5;
    end
    #(5*CLK_PERIOD);
    rst_n = 1;
    #(5*CLK_PERIOD);
    t_reset();
    t_no_inc_write();
    t_burst();
    t_wrap();
    t_read_only();
    t_bad_id();
    t_cut_short();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule